// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block condenses the architectural control state of a processor into one packed status word that the rest of the pipeline can read without re-deriving it. From the long-mode-active flag, the protection-enable and paging bits of control register 0, the code-segment long and default-size bits, the code-segment privilege level, the stack-segment default-size bit and the virtual-8086 flag, it forms an operating mode, a submode, the current privilege level, paging and protection flags, and the default and alternate size codes for operands, addresses and the stack.

The word sits in a register. It is recomputed from the present inputs only when the update strobe is high. Control logic pulses the strobe whenever one of the source bits may have changed. Between strobes the held word keeps its value, whatever the inputs do.

Top module: `omd_mode_decoder`

## Requirements
- R1: A synchronous active-low reset sets the word to mode legacy (0), submode real (0), privilege 0, paging 0, protection 0, and every size code (default/alternate operand, default/alternate address, stack) to 1. Reset takes priority over the strobe.
- R2: The word takes the value computed from the inputs at the clock edge where `upd` is high, so it appears one cycle later. On an edge where `upd` is low, every output keeps its value.
- R3: With `lma` set, the mode is long (1). The submode is 64-bit (4) when `cs_long` is set and compatibility (3) when it is clear.
- R4: With `lma` clear, the mode is legacy (0). The submode is real (0) when `pe` is clear. When `pe` is set it is virtual-8086 (1) if `vm` is set and protected (2) if `vm` is clear.
- R5: The privilege output equals `cs_dpl`. The paging output equals `pg` and the protection output equals `pe`.
- R6: Operand size is default 2 with alternate 1 when the submode is 64-bit or `cs_db` is set. Otherwise it is default 1 with alternate 2.
- R7: Address size is default 3 with alternate 2 in the 64-bit submode. Outside that submode it is default 2 with alternate 1 if `cs_db` is set, and default 1 with alternate 2 if not.
- R8: Stack size is 3 in the 64-bit submode. Outside it, the size is 2 if `ss_db` is set and 1 if not.
- R9: Size codes mean 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Code 0 never appears on any size output after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd | input | 1 | Recompute strobe |
| lma | input | 1 | Long mode active |
| pe | input | 1 | Protection enable |
| pg | input | 1 | Paging enable |
| cs_long | input | 1 | Code segment 64-bit attribute |
| cs_db | input | 1 | Code segment default size (1 = 32-bit) |
| cs_dpl | input | 2 | Code segment privilege level |
| ss_db | input | 1 | Stack segment default size (1 = 32-bit) |
| vm | input | 1 | Virtual-8086 flag |
| mode | output | 1 | 0 legacy, 1 long |
| submode | output | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| cpl | output | 2 | Current privilege level |
| paging | output | 1 | Paging flag |
| prot | output | 1 | Protection flag |
| def_op | output | 2 | Default operand size code |
| alt_op | output | 2 | Alternate operand size code |
| def_addr | output | 2 | Default address size code |
| alt_addr | output | 2 | Alternate address size code |
| stack_sz | output | 2 | Stack size code |

## Verification
The assertions assume that every input is a known value at each clock edge where the strobe is high, and that reset is applied from time zero. No other sequencing is assumed, so a strobe may come on every cycle or not at all. The stimulus drives every input only at falling edges. It visits all 512 combinations of the control inputs, and it interleaves cycles with the strobe low among them so that a changed input with no strobe is also covered. A reset arrives once in the middle of the run while the strobe is high.

// File: rtl/omd_pkg.sv
// Package: shared widths, encodings and the packed status word of the
// operating mode decoder. Assumes a two-bit privilege level.
package omd_pkg;
    localparam int CPL_W  = 2;
    localparam int SIZE_W = 2;
    localparam int SUB_W  = 3;

    typedef enum logic [0:0] {MODE_LEGACY = 1'b0, MODE_LONG = 1'b1} mode_e;

    typedef enum logic [SUB_W-1:0] {
        SUB_REAL   = 3'd0,
        SUB_V86    = 3'd1,
        SUB_PROT   = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    localparam logic [SIZE_W-1:0] SZ_16 = 2'd1;
    localparam logic [SIZE_W-1:0] SZ_32 = 2'd2;
    localparam logic [SIZE_W-1:0] SZ_64 = 2'd3;

    typedef struct packed {
        mode_e             mode;
        submode_e          submode;
        logic [CPL_W-1:0]  cpl;
        logic              paging;
        logic              prot;
        logic [SIZE_W-1:0] def_op;
        logic [SIZE_W-1:0] alt_op;
        logic [SIZE_W-1:0] def_addr;
        logic [SIZE_W-1:0] alt_addr;
        logic [SIZE_W-1:0] stack_sz;
    } status_t;

    localparam status_t STATUS_RESET = '{
        mode: MODE_LEGACY, submode: SUB_REAL, cpl: '0, paging: 1'b0,
        prot: 1'b0, def_op: SZ_16, alt_op: SZ_16, def_addr: SZ_16,
        alt_addr: SZ_16, stack_sz: SZ_16};
endpackage

// File: rtl/omd_submode_sel.sv
// Classifies the operating mode and submode from the long-mode-active,
// protection, virtual-8086 and code-segment 64-bit bits. Pure
// combinational; assumes all inputs are known when they are sampled.
module omd_submode_sel
    import omd_pkg::*;
(
    input  logic     lma,
    input  logic     pe,
    input  logic     vm,
    input  logic     cs_long,
    output mode_e    mode,
    output submode_e submode
);
    // Long-mode branch first, legacy branch by protection and VM.
    always_comb begin
        if (lma) begin
            mode    = MODE_LONG;
            submode = cs_long ? SUB_64 : SUB_COMPAT;
        end else begin
            mode = MODE_LEGACY;
            if (!pe)     submode = SUB_REAL;
            else if (vm) submode = SUB_V86;
            else         submode = SUB_PROT;
        end
    end
endmodule

// File: rtl/omd_size_sel.sv
// Chooses the operand, address and stack size codes from the submode and
// the two segment default-size bits. Address and stack follow their own
// precedence: 64-bit submode wins, then the relevant default-size bit.
module omd_size_sel
    import omd_pkg::*;
(
    input  submode_e          submode,
    input  logic              cs_db,
    input  logic              ss_db,
    output logic [SIZE_W-1:0] def_op,
    output logic [SIZE_W-1:0] alt_op,
    output logic [SIZE_W-1:0] def_addr,
    output logic [SIZE_W-1:0] alt_addr,
    output logic [SIZE_W-1:0] stack_sz
);
    logic is64;
    assign is64 = (submode == SUB_64);

    // Operand size: 32-bit default in 64-bit submode or wide code segment.
    always_comb begin
        if (is64 || cs_db) begin
            def_op = SZ_32;
            alt_op = SZ_16;
        end else begin
            def_op = SZ_16;
            alt_op = SZ_32;
        end
    end

    // Address size: 64-bit submode first, then code-segment size bit.
    always_comb begin
        if (is64) begin
            def_addr = SZ_64;
            alt_addr = SZ_32;
        end else if (cs_db) begin
            def_addr = SZ_32;
            alt_addr = SZ_16;
        end else begin
            def_addr = SZ_16;
            alt_addr = SZ_32;
        end
    end

    // Stack size: 64-bit submode first, then stack-segment size bit.
    always_comb begin
        if (is64)       stack_sz = SZ_64;
        else if (ss_db) stack_sz = SZ_32;
        else            stack_sz = SZ_16;
    end
endmodule

// File: rtl/omd_status_reg.sv
// Holds the status word. Loads the next value on the strobe and clears
// to the reset value under synchronous active-low reset.
module omd_status_reg
    import omd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd,
    input  status_t d,
    output status_t q
);
    // Register with reset priority over the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= STATUS_RESET;
        else if (upd) q <= d;
    end

    // R2: without a strobe the word holds.
    assert_hold_no_upd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));

    // R2: with a strobe the word follows the computed value.
    assert_load_on_upd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (q == $past(d)));
endmodule

// File: rtl/omd_mode_decoder.sv
// Top of the operating mode decoder. Combines the mode classifier and the
// size selector into a status word, registers it on the update strobe,
// and breaks it out onto ports. Assumes inputs are known on strobe edges.
module omd_mode_decoder
    import omd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              lma,
    input  logic              pe,
    input  logic              pg,
    input  logic              cs_long,
    input  logic              cs_db,
    input  logic [CPL_W-1:0]  cs_dpl,
    input  logic              ss_db,
    input  logic              vm,
    output logic              mode,
    output logic [SUB_W-1:0]  submode,
    output logic [CPL_W-1:0]  cpl,
    output logic              paging,
    output logic              prot,
    output logic [SIZE_W-1:0] def_op,
    output logic [SIZE_W-1:0] alt_op,
    output logic [SIZE_W-1:0] def_addr,
    output logic [SIZE_W-1:0] alt_addr,
    output logic [SIZE_W-1:0] stack_sz
);
    mode_e    nx_mode;
    submode_e nx_sub;
    status_t  nx_word;
    status_t  word_q;
    logic [SIZE_W-1:0] nx_def_op, nx_alt_op, nx_def_addr, nx_alt_addr, nx_stack;

    omd_submode_sel u_mode (
        .lma(lma), .pe(pe), .vm(vm), .cs_long(cs_long),
        .mode(nx_mode), .submode(nx_sub)
    );

    omd_size_sel u_size (
        .submode(nx_sub), .cs_db(cs_db), .ss_db(ss_db),
        .def_op(nx_def_op), .alt_op(nx_alt_op),
        .def_addr(nx_def_addr), .alt_addr(nx_alt_addr), .stack_sz(nx_stack)
    );

    // Assemble the next status word from both selectors and direct copies.
    always_comb begin
        nx_word.mode     = nx_mode;
        nx_word.submode  = nx_sub;
        nx_word.cpl      = cs_dpl;
        nx_word.paging   = pg;
        nx_word.prot     = pe;
        nx_word.def_op   = nx_def_op;
        nx_word.alt_op   = nx_alt_op;
        nx_word.def_addr = nx_def_addr;
        nx_word.alt_addr = nx_alt_addr;
        nx_word.stack_sz = nx_stack;
    end

    omd_status_reg u_reg (
        .clk(clk), .rst_n(rst_n), .upd(upd), .d(nx_word), .q(word_q)
    );

    // Break the held word out onto the ports.
    always_comb begin
        mode     = word_q.mode;
        submode  = word_q.submode;
        cpl      = word_q.cpl;
        paging   = word_q.paging;
        prot     = word_q.prot;
        def_op   = word_q.def_op;
        alt_op   = word_q.alt_op;
        def_addr = word_q.def_addr;
        alt_addr = word_q.alt_addr;
        stack_sz = word_q.stack_sz;
    end

    // R1: reset yields the real-mode, all-16-bit word.
    assert_reset_word_R1: assert property (@(posedge clk)
        !rst_n |=> (word_q == STATUS_RESET));

    // R3: long mode with the 64-bit code attribute gives the 64-bit submode.
    assert_long_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && lma) |=> (mode == 1'b1) && (submode == ($past(cs_long) ? 3'd4 : 3'd3)));

    // R4: legacy submodes never exceed protected.
    assert_legacy_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b0) |-> (submode <= 3'd2));

    // R5: privilege and flags follow their sources on a strobe.
    assert_copy_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (cpl == $past(cs_dpl)) && (paging == $past(pg)) && (prot == $past(pe)));

    // R8: a 64-bit stack exactly in the 64-bit submode.
    assert_stack64_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_sz == 2'd3) == (submode == 3'd4));

    // R9: no size code is ever zero.
    assert_no_zero_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (def_op != 0) && (alt_op != 0) && (def_addr != 0) && (alt_addr != 0) && (stack_sz != 0));
endmodule

// File: tb/test_omd_mode_decoder.sv
module test_omd_mode_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0, lma = 1'b0, pe = 1'b0, pg = 1'b0, cs_long = 1'b0;
    logic cs_db = 1'b0, ss_db = 1'b0, vm = 1'b0;
    logic [1:0] cs_dpl = 2'd0;
    logic mode, paging, prot;
    logic [2:0] submode;
    logic [1:0] cpl, def_op, alt_op, def_addr, alt_addr, stack_sz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state: expected outputs as integers.
    int e_mode, e_sub, e_cpl, e_pg, e_pe, e_dop, e_aop, e_dad, e_aad, e_stk;

    always #(CLK_PERIOD/2) clk = ~clk;

    omd_mode_decoder i_omd_mode_decoder (
        .clk(clk), .rst_n(rst_n), .upd(upd), .lma(lma), .pe(pe), .pg(pg),
        .cs_long(cs_long), .cs_db(cs_db), .cs_dpl(cs_dpl), .ss_db(ss_db),
        .vm(vm), .mode(mode), .submode(submode), .cpl(cpl), .paging(paging),
        .prot(prot), .def_op(def_op), .alt_op(alt_op), .def_addr(def_addr),
        .alt_addr(alt_addr), .stack_sz(stack_sz)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        e_mode = 0; e_sub = 0; e_cpl = 0; e_pg = 0; e_pe = 0;
        e_dop = 1; e_aop = 1; e_dad = 1; e_aad = 1; e_stk = 1;
    endtask

    // Behavioural evaluation of the requirements from the driven inputs.
    task automatic model_load();
        bit w64;
        if (lma) begin
            e_mode = 1; e_sub = cs_long ? 4 : 3;
        end else begin
            e_mode = 0;
            e_sub = !pe ? 0 : (vm ? 1 : 2);
        end
        w64 = (e_sub == 4);
        e_cpl = cs_dpl; e_pg = pg; e_pe = pe;
        e_dop = (w64 || cs_db) ? 2 : 1;
        e_aop = 3 - e_dop;
        if (w64)        begin e_dad = 3; e_aad = 2; end
        else if (cs_db) begin e_dad = 2; e_aad = 1; end
        else            begin e_dad = 1; e_aad = 2; end
        e_stk = w64 ? 3 : (ss_db ? 2 : 1);
    endtask

    task automatic compare_all(input bool_long, input bit was_upd);
        string rq;
        rq = bool_long ? "R3" : "R4";
        check(rq, "mode", mode, e_mode);
        check(rq, "submode", submode, e_sub);
        check("R5", "cpl", cpl, e_cpl);
        check("R5", "paging", paging, e_pg);
        check("R5", "prot", prot, e_pe);
        check("R6", "def_op", def_op, e_dop);
        check("R6", "alt_op", alt_op, e_aop);
        check("R7", "def_addr", def_addr, e_dad);
        check("R7", "alt_addr", alt_addr, e_aad);
        check("R8", "stack_sz", stack_sz, e_stk);
        // R9: size code zero never seen
        check("R9", "nonzero sizes",
              (def_op != 0 && alt_op != 0 && def_addr != 0 && alt_addr != 0 && stack_sz != 0), 1);
        if (!was_upd) check("R2", "hold submode", submode, e_sub);
    endtask

    // Drive one cycle at a falling edge, then compare at the next falling edge.
    task automatic step(input int pattern, input bit strobe, input bit rst_v);
        {lma, pe, pg, cs_long, cs_db, cs_dpl, ss_db, vm} = pattern[8:0];
        upd = strobe;
        rst_n = rst_v;
        if (!rst_v)      model_reset();
        else if (strobe) model_load();
        @(negedge clk);
        compare_all(e_mode == 1, strobe);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with busy inputs and strobe high
        step(9'h1FF, 1'b1, 1'b0);
        step(9'h1FF, 1'b1, 1'b0);
        check("R1", "reset def_op", def_op, 1);
        check("R1", "reset alt_op", alt_op, 1);
        check("R1", "reset submode", submode, 0);
        // R2: input change with no strobe leaves word at reset value
        step(9'h1FF, 1'b0, 1'b1);
        check("R2", "no strobe keeps stack", stack_sz, 1);
        for (int i = 0; i < 1536; i++) begin
            step(i % 512, (i % 3) != 0, 1'b1);
            if (i == 700) begin
                step(9'h1F3, 1'b1, 1'b0);
                check("R1", "mid-run reset mode", mode, 0);
            end
        end
        // R3: explicit 64-bit and compatibility cases
        step(9'b1_0_0_1_0_00_0_0, 1'b1, 1'b1);
        check("R3", "64-bit submode", submode, 4);
        step(9'b1_0_0_0_1_00_1_0, 1'b1, 1'b1);
        check("R3", "compat submode", submode, 3);
        check("R7", "compat wide addr", def_addr, 2);
        // R4: virtual-8086
        step(9'b0_1_0_0_0_11_0_1, 1'b1, 1'b1);
        check("R4", "v86 submode", submode, 1);
        check("R5", "cpl 3", cpl, 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: counts a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule